// File: doc/BRIEF.md
# Descriptor-Chain SPI Transfer Sequencer

This block runs a list of SPI transfers, each with its own configuration, without the CPU stepping in between them. Software places a table of fixed-size entries in memory. Each entry is 24 bytes long and holds six 32-bit words, in this order: a start word, a bus word, a 64-bit transmit address and a 64-bit receive address. Software then starts the chain in one of two ways. It can write a single register, or it can arm a trigger so that an edge on an external sync pin starts the chain.

The sequencer fetches each entry one word at a time through a simple request/acknowledge memory read port. It hands the assembled entry to a serial bus engine with a one-cycle launch pulse and waits for the engine to report that it is done. It then moves on to the next entry, 24 bytes further on. It stops after the entry whose start word has the end-of-chain flag. The data mover and the bit shifter sit outside this block. The data mover reports its channel events through an eight-bit event input. The sequencer keeps a write-1-to-clear status register, a mask register that drives the interrupt line, a claim semaphore and a readable pointer to the entry it is currently working on.

Top module: `spi_desc_chain`

## Requirements
- R1: An entry is read as six 32-bit words from byte addresses entry+0, +4, +8, +12, +16 and +20, in this order: start word, bus word, transmit low, transmit high, receive low, receive high. A memory request stays high with a stable address until it is acknowledged. After the sixth word, `eng_start` pulses for one cycle with the whole entry on the engine outputs.
- R2: When the block is idle, a write to offset 0x24 with bit 31 set starts a chain. The first entry address is {write data bits [ADDR_W-33:0], register 0x20}. The same write while a chain is running is ignored.
- R3: After each `eng_done`, the next entry is fetched 24 bytes higher. This continues until an entry has start-word bit 30 set. Once that entry is done, the block goes idle and sets status bit 11.
- R4: Status bit 10 is set each time an entry is done. Status bit 9 is set whenever the block goes from busy to idle.
- R5: Bit 6 of the configuration register at 0x04 makes a rising edge of `sync_in` start a chain at the stored base address when idle. Bit 7 does the same for a falling edge. The edge that is not selected starts nothing.
- R6: Writing exactly 0 to 0x24 during a chain aborts it. `eng_abort` pulses once, no further fetch or launch happens, status bit 9 is set and bit 11 stays clear.
- R7: A fetch acknowledged with `mem_err` sets status bit 8 and halts the chain. The entry that was being fetched is never launched.
- R8: Status at 0x30 is write-1-to-clear. `chan_evt[7:0]` sets status bits 7:0. If a bit is set and cleared in the same cycle, the set wins.
- R9: `irq` is high exactly when some status bit is set whose enable bit at 0x34 is also set.
- R10: The semaphore at 0x00 reads 1 after reset. A write stores bit 0 of the write data, so writing 0 claims it and writing 1 releases it.
- R11: Offsets 0x28/0x2C read the address of the entry being fetched or executed, low and high halves. They read 0 after reset and keep the last entry's address after the chain ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_ack | input | 1 | Read acknowledge; data and error valid |
| mem_rdata | input | 32 | Read data |
| mem_err | input | 1 | Read error, qualified by `mem_ack` |
| eng_start | output | 1 | One-cycle launch pulse to the bus engine |
| eng_start_word | output | 32 | Start word of the current entry |
| eng_bus_word | output | 32 | Bus word of the current entry |
| eng_tx_addr | output | 64 | Transmit address of the current entry |
| eng_rx_addr | output | 64 | Receive address of the current entry |
| eng_done | input | 1 | Engine finished the launched entry |
| eng_abort | output | 1 | One-cycle pulse telling the engine to stop |
| chan_evt | input | 8 | Data-mover event pulses for status bits 7:0 |
| sync_in | input | 1 | Asynchronous external start sync |
| irq | output | 1 | Masked interrupt |

## Verification
A status-clear write and a data-mover event can land on the same status bit in the same clock cycle. The bench first sets two channel bits. It then writes a clear for both in the very cycle that it pulses an event on only one of them. It expects the re-raised bit to survive and the other to be cleared. A second collision is also exercised. A pending write or a sync edge can coincide with a chain that is still running. Here the bench expects the running chain's launched entries to be exactly the entries that were planned, with no restart.

// File: rtl/spi_desc_chain_pkg.sv
package spi_desc_chain_pkg;
   localparam logic [5:0] OFS_SEM    = 6'h00;
   localparam logic [5:0] OFS_CFG    = 6'h04;
   localparam logic [5:0] OFS_BASE_L = 6'h20;
   localparam logic [5:0] OFS_BASE_H = 6'h24;
   localparam logic [5:0] OFS_CUR_L  = 6'h28;
   localparam logic [5:0] OFS_CUR_H  = 6'h2C;
   localparam logic [5:0] OFS_STS    = 6'h30;
   localparam logic [5:0] OFS_ENA    = 6'h34;

   localparam int STS_W       = 12;
   localparam int BIT_DERR    = 8;
   localparam int BIT_IDLE    = 9;
   localparam int BIT_ONE     = 10;
   localparam int BIT_CHAIN   = 11;
   localparam int BIT_LAST    = 30;
   localparam int BIT_GO      = 31;
   localparam int BIT_TRIG_R  = 6;
   localparam int BIT_TRIG_F  = 7;

   localparam int ENTRY_WORDS = 6;
   localparam int ENTRY_BYTES = 24;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_FETCH,
      SQ_LAUNCH,
      SQ_WAIT
   } seq_state_e;

   typedef struct packed {
      logic [31:0] start_w;
      logic [31:0] bus_w;
      logic [63:0] tx_addr;
      logic [63:0] rx_addr;
   } entry_t;
endpackage

// File: rtl/spi_desc_chain_sync.sv
module spi_desc_chain_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise,
   output logic fall
);
   if (STAGES < 1) begin : g_bad_stages
      $error("STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= async_in;
      end
   end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], async_in};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign rise = chain_q[STAGES-1] & ~prev_q;
   assign fall = ~chain_q[STAGES-1] & prev_q;

   assert_edge_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rise || fall) |=> !(rise || fall));
endmodule

// File: rtl/spi_desc_chain_regs.sv
module spi_desc_chain_regs
   import spi_desc_chain_pkg::*;
#(
   parameter int ADDR_W = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [5:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              busy,
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [STS_W-1:0]  set_vec,
   output logic [31:0]       cfg_q,
   output logic [ADDR_W-1:0] base_addr,
   output logic [ADDR_W-1:0] go_base,
   output logic              go_sw,
   output logic              abort_sw,
   output logic              irq
);
   localparam int HI_W = ADDR_W - 32;

   logic             sem_q;
   logic [31:0]      lo_q;
   logic [30:0]      hi_q;
   logic [STS_W-1:0] sts_q;
   logic [STS_W-1:0] ena_q;
   logic [STS_W-1:0] clr_vec;
   logic [63:0]      cur_ext;
   logic             hi_wr;

   assign hi_wr    = reg_wr && (reg_addr == OFS_BASE_H);
   assign go_sw    = hi_wr && reg_wdata[BIT_GO] && !busy;
   assign abort_sw = hi_wr && (reg_wdata == 32'd0) && busy;
   assign go_base  = {reg_wdata[HI_W-1:0], lo_q};
   assign base_addr = {hi_q[HI_W-1:0], lo_q};
   assign clr_vec  = (reg_wr && reg_addr == OFS_STS) ? reg_wdata[STS_W-1:0] : '0;
   assign cur_ext  = 64'(cur_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sem_q <= 1'b1;
         cfg_q <= '0;
         lo_q  <= '0;
         hi_q  <= '0;
         ena_q <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            OFS_SEM:    sem_q <= reg_wdata[0];
            OFS_CFG:    cfg_q <= reg_wdata;
            OFS_BASE_L: lo_q  <= reg_wdata;
            OFS_BASE_H: hi_q  <= reg_wdata[30:0];
            OFS_ENA:    ena_q <= reg_wdata[STS_W-1:0];
            default:    ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q <= '0;
      else        sts_q <= (sts_q & ~clr_vec) | set_vec;
   end

   assign irq = |(sts_q & ena_q);

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         OFS_SEM:    reg_rdata = {31'd0, sem_q};
         OFS_CFG:    reg_rdata = cfg_q;
         OFS_BASE_L: reg_rdata = lo_q;
         OFS_BASE_H: reg_rdata = {busy, hi_q};
         OFS_CUR_L:  reg_rdata = cur_ext[31:0];
         OFS_CUR_H:  reg_rdata = cur_ext[63:32];
         OFS_STS:    reg_rdata = 32'(sts_q);
         OFS_ENA:    reg_rdata = 32'(ena_q);
         default:    reg_rdata = '0;
      endcase
   end

   assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == OFS_STS && set_vec == '0)
      |=> ((sts_q & $past(reg_wdata[STS_W-1:0])) == '0));

   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((sts_q & $past(set_vec)) == $past(set_vec)));

   assert_sem_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == OFS_SEM) |=> (sem_q == $past(reg_wdata[0])));
endmodule

// File: rtl/spi_desc_chain_seq.sv
module spi_desc_chain_seq
   import spi_desc_chain_pkg::*;
#(
   parameter int ADDR_W = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [ADDR_W-1:0] go_addr,
   input  logic              abort,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_err,
   output logic              eng_start,
   output entry_t            eng_entry,
   input  logic              eng_done,
   output logic              eng_abort,
   output logic              busy,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              ev_derr,
   output logic              ev_one,
   output logic              ev_chain,
   output logic              ev_idle
);
   localparam int IDX_W = $clog2(ENTRY_WORDS);

   seq_state_e        state_q;
   logic [IDX_W-1:0]  idx_q;
   logic [ADDR_W-1:0] cur_q;
   logic [31:0]       wd_q [ENTRY_WORDS];
   logic              abort_q;
   logic              last_ent;

   assign busy      = (state_q != SQ_IDLE);
   assign mem_req   = (state_q == SQ_FETCH);
   assign mem_addr  = cur_q + ADDR_W'({idx_q, 2'b00});
   assign eng_start = (state_q == SQ_LAUNCH);
   assign eng_abort = abort_q;
   assign cur_addr  = cur_q;
   assign last_ent  = wd_q[0][BIT_LAST];

   assign eng_entry.start_w = wd_q[0];
   assign eng_entry.bus_w   = wd_q[1];
   assign eng_entry.tx_addr = {wd_q[3], wd_q[2]};
   assign eng_entry.rx_addr = {wd_q[5], wd_q[4]};

   assign ev_derr  = (state_q == SQ_FETCH) && mem_ack && mem_err && !abort;
   assign ev_one   = (state_q == SQ_WAIT) && eng_done && !abort;
   assign ev_chain = ev_one && last_ent;
   assign ev_idle  = ev_chain || ev_derr || (abort && busy);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) abort_q <= 1'b0;
      else        abort_q <= abort && busy;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         idx_q   <= '0;
         cur_q   <= '0;
         for (int k = 0; k < ENTRY_WORDS; k++) wd_q[k] <= '0;
      end else if (abort && busy) begin
         state_q <= SQ_IDLE;
      end else begin
         case (state_q)
            SQ_IDLE: begin
               if (go) begin
                  cur_q   <= go_addr;
                  idx_q   <= '0;
                  state_q <= SQ_FETCH;
               end
            end
            SQ_FETCH: begin
               if (mem_ack) begin
                  if (mem_err) begin
                     state_q <= SQ_IDLE;
                  end else begin
                     for (int k = 0; k < ENTRY_WORDS; k++)
                        if (idx_q == IDX_W'(k)) wd_q[k] <= mem_rdata;
                     if (idx_q == IDX_W'(ENTRY_WORDS - 1)) state_q <= SQ_LAUNCH;
                     else idx_q <= idx_q + 1'b1;
                  end
               end
            end
            SQ_LAUNCH: state_q <= SQ_WAIT;
            SQ_WAIT: begin
               if (eng_done) begin
                  if (last_ent) begin
                     state_q <= SQ_IDLE;
                  end else begin
                     cur_q   <= cur_q + ADDR_W'(ENTRY_BYTES);
                     idx_q   <= '0;
                     state_q <= SQ_FETCH;
                  end
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack && !abort) |=> (mem_req && $stable(mem_addr)));

   assert_launch_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);

   assert_last_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_WAIT && eng_done && last_ent && !abort) |=> !busy);

   assert_abort_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (abort && busy) |=> (!mem_req && !eng_start && eng_abort));

   assert_err_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && mem_err) |=> (!mem_req && !eng_start));
endmodule

// File: rtl/spi_desc_chain.sv
module spi_desc_chain
   import spi_desc_chain_pkg::*;
#(
   parameter int ADDR_W      = 40,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [5:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_err,
   output logic              eng_start,
   output logic [31:0]       eng_start_word,
   output logic [31:0]       eng_bus_word,
   output logic [63:0]       eng_tx_addr,
   output logic [63:0]       eng_rx_addr,
   input  logic              eng_done,
   output logic              eng_abort,
   input  logic [7:0]        chan_evt,
   input  logic              sync_in,
   output logic              irq
);
   if (ADDR_W < 33 || ADDR_W > 63) begin : g_bad_addr_w
      $error("ADDR_W must lie in 33..63");
   end

   logic              busy, go_sw, abort_sw, go, trig_go;
   logic              s_rise, s_fall;
   logic              ev_derr, ev_one, ev_chain, ev_idle;
   logic [31:0]       cfg_q;
   logic [ADDR_W-1:0] base_addr, go_base, start_addr, cur_addr;
   logic [STS_W-1:0]  set_vec;
   entry_t            entry;

   assign set_vec = {ev_chain, ev_one, ev_idle, ev_derr, chan_evt};
   assign trig_go = !busy && ((cfg_q[BIT_TRIG_R] && s_rise) ||
                              (cfg_q[BIT_TRIG_F] && s_fall));
   assign go         = go_sw || trig_go;
   assign start_addr = go_sw ? go_base : base_addr;

   assign eng_start_word = entry.start_w;
   assign eng_bus_word   = entry.bus_w;
   assign eng_tx_addr    = entry.tx_addr;
   assign eng_rx_addr    = entry.rx_addr;

   spi_desc_chain_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(sync_in), .rise(s_rise), .fall(s_fall)
   );

   spi_desc_chain_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
      .cur_addr(cur_addr), .set_vec(set_vec), .cfg_q(cfg_q),
      .base_addr(base_addr), .go_base(go_base), .go_sw(go_sw),
      .abort_sw(abort_sw), .irq(irq)
   );

   spi_desc_chain_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .go_addr(start_addr), .abort(abort_sw),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .mem_err(mem_err), .eng_start(eng_start),
      .eng_entry(entry), .eng_done(eng_done), .eng_abort(eng_abort),
      .busy(busy), .cur_addr(cur_addr), .ev_derr(ev_derr), .ev_one(ev_one),
      .ev_chain(ev_chain), .ev_idle(ev_idle)
   );

   assert_trig_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && (s_rise || s_fall) && !go_sw) |=> $stable(cur_addr) || !busy);
endmodule

// File: tb/spi_desc_chain_bench.sv
module spi_desc_chain_bench;
   localparam int AW = 40;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [5:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          mem_req;
   logic [AW-1:0] mem_addr;
   logic          mem_ack = 1'b0;
   logic [31:0]   mem_rdata = '0;
   logic          mem_err = 1'b0;
   logic          eng_start;
   logic [31:0]   eng_start_word, eng_bus_word;
   logic [63:0]   eng_tx_addr, eng_rx_addr;
   logic          eng_done = 1'b0;
   logic          eng_abort;
   logic [7:0]    chan_evt = '0;
   logic          sync_in = 1'b0;
   logic          irq;

   always #2 clk = ~clk;

   spi_desc_chain #(.ADDR_W(AW), .SYNC_STAGES(2)) u_spi_desc_chain (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .mem_err(mem_err), .eng_start(eng_start), .eng_start_word(eng_start_word),
      .eng_bus_word(eng_bus_word), .eng_tx_addr(eng_tx_addr),
      .eng_rx_addr(eng_rx_addr), .eng_done(eng_done), .eng_abort(eng_abort),
      .chan_evt(chan_evt), .sync_in(sync_in), .irq(irq)
   );

   int total = 0, bad = 0;
   bit finished = 1'b0;

   logic [31:0] mem [512];
   logic [AW-1:0] err_addr = '1;
   int mem_wait = 0;

   logic [31:0] cap_s [16], cap_b [16];
   logic [63:0] cap_t [16], cap_r [16];
   int cap_n = 0, abort_seen = 0, eng_cnt = 0, eng_lat = 0;

   logic [31:0] ex_s [8], ex_b [8];
   logic [63:0] ex_t [8], ex_r [8];

   always @(negedge clk) begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
      if (mem_req) begin
         if (mem_wait == 0) begin
            mem_ack   = 1'b1;
            mem_rdata = mem[mem_addr[10:2]];
            mem_err   = (mem_addr == err_addr);
            mem_wait  = $urandom % 3;
         end else mem_wait--;
      end
   end

   always @(negedge clk) begin
      eng_done = 1'b0;
      if (eng_abort) begin
         abort_seen++;
         eng_cnt = 0;
      end else if (eng_start) begin
         if (cap_n < 16) begin
            cap_s[cap_n] = eng_start_word;
            cap_b[cap_n] = eng_bus_word;
            cap_t[cap_n] = eng_tx_addr;
            cap_r[cap_n] = eng_rx_addr;
         end
         cap_n++;
         eng_cnt = (eng_lat > 0) ? eng_lat : 1 + int'($urandom % 4);
      end else if (eng_cnt > 0) begin
         eng_cnt--;
         if (eng_cnt == 0) eng_done = 1'b1;
      end
   end

   task automatic check(input bit ok, input string tag, input logic [63:0] act,
                        input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   function automatic logic [31:0] exp_sts_chain_ok();
      return 32'h0000_0E00;
   endfunction

   function automatic logic [31:0] exp_cur(input int base, input int n);
      return 32'(base + 24 * (n - 1));
   endfunction

   task automatic build_chain(input int base, input int n);
      for (int k = 0; k < n; k++) begin
         logic [31:0] s;
         int w;
         s = $urandom & ~(32'd1 << 30);
         if (k == n - 1) s = s | (32'd1 << 30);
         ex_s[k] = s;
         ex_b[k] = $urandom;
         ex_t[k] = {$urandom, $urandom};
         ex_r[k] = {$urandom, $urandom};
         w = (base + 24 * k) / 4;
         mem[w]     = ex_s[k];
         mem[w + 1] = ex_b[k];
         mem[w + 2] = ex_t[k][31:0];
         mem[w + 3] = ex_t[k][63:32];
         mem[w + 4] = ex_r[k][31:0];
         mem[w + 5] = ex_r[k][63:32];
      end
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      bit seen = 1'b0;
      for (int i = 0; i < 3000; i++) begin
         rd(6'h30, v);
         if (v[9]) begin seen = 1'b1; break; end
      end
      check(seen, "R4 ready bit 9 reached", 64'(v), 64'h200);
   endtask

   task automatic cmp_entries(input int n, input string tag);
      for (int k = 0; k < n; k++) begin
         check(cap_s[k] == ex_s[k], tag, 64'(cap_s[k]), 64'(ex_s[k]));
         check(cap_b[k] == ex_b[k], tag, 64'(cap_b[k]), 64'(ex_b[k]));
         check(cap_t[k] == ex_t[k], tag, cap_t[k], ex_t[k]);
         check(cap_r[k] == ex_r[k], tag, cap_r[k], ex_r[k]);
      end
   endtask

   task automatic clear_sts();
      logic [31:0] v;
      rd(6'h30, v);
      wr(6'h30, v);
   endtask

   initial begin
      logic [31:0] v;
      int base, n, seed_v;
      seed_v = int'($urandom(32'd20240917));
      for (int i = 0; i < 512; i++) mem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state: R10, R11, R9, R1
      rd(6'h00, v); check(v == 32'd1, "R10 semaphore reset", 64'(v), 64'd1);
      rd(6'h28, v); check(v == 32'd0, "R11 current addr reset", 64'(v), 64'd0);
      rd(6'h30, v); check(v == 32'd0, "R8 status reset", 64'(v), 64'd0);
      check(irq == 1'b0, "R9 irq reset", 64'(irq), 64'd0);
      check(mem_req == 1'b0 && eng_start == 1'b0, "R1 idle outputs", 64'(mem_req), 64'd0);

      // R10 claim and release
      wr(6'h00, 32'd0); rd(6'h00, v); check(v == 32'd0, "R10 claim", 64'(v), 64'd0);
      wr(6'h00, 32'd1); rd(6'h00, v); check(v == 32'd1, "R10 release", 64'(v), 64'd1);
      wr(6'h04, 32'h0000_00A5); rd(6'h04, v);
      check(v == 32'hA5, "R5 config readback", 64'(v), 64'hA5);
      wr(6'h04, 32'd0);
      wr(6'h34, 32'h0000_0FFF);

      // random chains: R1 R2 R3 R4 R9 R11
      for (int it = 0; it < 8; it++) begin
         n = 1 + int'($urandom % 4);
         base = int'($urandom % 64) * 8;
         build_chain(base, n);
         eng_lat = 0; cap_n = 0;
         wr(6'h20, 32'(base));
         wr(6'h24, 32'h8000_0000);
         wait_idle();
         repeat (4) @(negedge clk);
         check(cap_n == n, "R3 entry count", 64'(cap_n), 64'(n));
         cmp_entries(n, "R1 entry fields");
         rd(6'h30, v); check(v == exp_sts_chain_ok(), "R3 R4 status after chain", 64'(v), 64'(exp_sts_chain_ok()));
         check(irq == 1'b1, "R9 irq with status", 64'(irq), 64'd1);
         rd(6'h28, v); check(v == exp_cur(base, n), "R11 last entry addr", 64'(v), 64'(exp_cur(base, n)));
         rd(6'h2C, v); check(v == 32'd0, "R11 upper addr", 64'(v), 64'd0);
         clear_sts();
         rd(6'h30, v); check(v == 32'd0, "R8 clear all", 64'(v), 64'd0);
      end

      // R2 pending ignored while busy
      build_chain(64, 2); eng_lat = 12; cap_n = 0;
      wr(6'h20, 32'd64); wr(6'h24, 32'h8000_0000);
      for (int i = 0; i < 500 && cap_n < 1; i++) @(negedge clk);
      wr(6'h20, 32'd256); wr(6'h24, 32'h8000_0000);
      wait_idle(); repeat (20) @(negedge clk);
      check(cap_n == 2, "R2 busy go ignored count", 64'(cap_n), 64'd2);
      cmp_entries(2, "R2 busy go ignored fields");
      clear_sts();

      // R6 abort
      build_chain(128, 3); eng_lat = 40; cap_n = 0; abort_seen = 0;
      wr(6'h20, 32'd128); wr(6'h24, 32'h8000_0000);
      for (int i = 0; i < 500 && cap_n < 1; i++) @(negedge clk);
      wr(6'h24, 32'd0);
      repeat (80) @(negedge clk);
      check(cap_n == 1, "R6 no launch after abort", 64'(cap_n), 64'd1);
      check(abort_seen == 1, "R6 abort pulse", 64'(abort_seen), 64'd1);
      check(mem_req == 1'b0, "R6 no fetch after abort", 64'(mem_req), 64'd0);
      rd(6'h30, v); check(v == 32'h200, "R6 status after abort", 64'(v), 64'h200);
      clear_sts();

      // R7 fetch error in the second entry
      build_chain(192, 3); eng_lat = 0; cap_n = 0;
      err_addr = AW'(192 + 24 + 8);
      wr(6'h20, 32'd192); wr(6'h24, 32'h8000_0000);
      wait_idle(); repeat (10) @(negedge clk);
      check(cap_n == 1, "R7 partial entry not launched", 64'(cap_n), 64'd1);
      rd(6'h30, v); check(v == 32'h700, "R7 status derr", 64'(v), 64'h700);
      err_addr = '1;
      clear_sts();

      // R5 sync edges
      build_chain(320, 1); cap_n = 0;
      wr(6'h04, 32'h40); wr(6'h20, 32'd320); wr(6'h24, 32'd0);
      @(negedge clk); sync_in = 1'b1;
      wait_idle(); repeat (4) @(negedge clk);
      check(cap_n == 1, "R5 rising start", 64'(cap_n), 64'd1);
      cmp_entries(1, "R5 rising entry");
      clear_sts(); cap_n = 0;
      @(negedge clk); sync_in = 1'b0;
      repeat (30) @(negedge clk);
      check(cap_n == 0, "R5 falling ignored on rise mode", 64'(cap_n), 64'd0);
      wr(6'h04, 32'h80);
      @(negedge clk); sync_in = 1'b1;
      repeat (30) @(negedge clk);
      check(cap_n == 0, "R5 rising ignored on fall mode", 64'(cap_n), 64'd0);
      @(negedge clk); sync_in = 1'b0;
      wait_idle(); repeat (4) @(negedge clk);
      check(cap_n == 1, "R5 falling start", 64'(cap_n), 64'd1);
      wr(6'h04, 32'd0);
      clear_sts();

      // R8 collision: set wins; R9 masking
      @(negedge clk); chan_evt = 8'h0C;
      @(negedge clk); chan_evt = 8'h00;
      rd(6'h30, v); check(v == 32'h0C, "R8 channel events", 64'(v), 64'h0C);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 6'h30; reg_wdata = 32'h0C; chan_evt = 8'h08;
      @(negedge clk);
      reg_wr = 1'b0; chan_evt = 8'h00;
      rd(6'h30, v); check(v == 32'h08, "R8 set beats clear", 64'(v), 64'h08);
      wr(6'h34, 32'h0); #1 check(irq == 1'b0, "R9 masked", 64'(irq), 64'd0);
      wr(6'h34, 32'h4); #1 check(irq == 1'b0, "R9 other bit", 64'(irq), 64'd0);
      wr(6'h34, 32'h8); #1 check(irq == 1'b1, "R9 enabled bit", 64'(irq), 64'd1);
      wr(6'h30, 32'h8);
      rd(6'h30, v); check(v == 32'h0, "R8 plain clear", 64'(v), 64'h0);

      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule